// File: doc/BRIEF.md
# Cyclic Cell Spreader with Shared Output Buffers

This block sits on the output side of one port of a fully connected cell switch. Each slot, up to four cells that are already destined for this port arrive on parallel lanes. They are packed so that the occupied lanes are always the lowest-numbered ones. The block deals these cells round the four buffers in turn, so that the buffers fill evenly. It then sends at most one cell per slot onto the single output line, taking the buffers in the same circular order.

Because the buffers fill and empty in the same rotation, cells leave in the order they arrived. When the read side reaches an empty buffer, it stays on that buffer. That buffer is the next one to receive a cell. A cell that lands in the buffer under the read pointer while that buffer is empty is sent out in the same slot. A cell written into a full buffer is lost, and a per-buffer flag records the loss.

Top module: `rr_spread_buf`

## Requirements
- R1: After reset, `cellValid` and all `overflow` bits are 0. The first cell accepted goes to buffer 1, and reading begins at buffer 1.
- R2: On a slot with k valid lanes and write pointer w, lane i goes to buffer (w+i) mod 4. The write pointer then advances by k modulo 4.
- R3: On each slot where the buffer under the read pointer r holds a cell, the head of buffer r is output, and r advances by one modulo 4.
- R4: If buffer r is empty at a slot and no cell lands in it that slot, `cellValid` is 0 after that slot and r does not move.
- R5: If buffer r is empty at a slot and a lane targets r in that slot, that lane's cell is output after that same slot edge without being stored, and r advances. A cell that lands in any other buffer is output only in a later slot.
- R6: A cell aimed at a buffer that holds DEPTH cells at the start of the slot is dropped, even if that buffer is read in the same slot. The cell sets bit b of `overflow` for target buffer b, and the bit stays set until reset. The write pointer still advances past that buffer.
- R7: `cellValid` and `cellData` change only at clock edges where `slotStb` is 1. Lane inputs on other cycles have no effect. `cellValid` is 0 after a slot that delivers no cell.
- R8: When no cell is dropped, cells leave in the order they arrived: lane order within a slot, slot order across slots.
- R9: `laneValid` is packed, so each slot's valid lanes form the set {0..k-1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStb | input | 1 | Marks the clock edge that closes a cell slot |
| laneValid | input | 4 | Occupied lanes, packed toward lane 0 |
| laneData | input | 4*WIDTH | Lane payloads, lane i in bits [i*WIDTH +: WIDTH] |
| cellValid | output | 1 | Output cell present for the current slot |
| cellData | output | WIDTH | Output cell payload |
| overflow | output | 4 | Sticky per-buffer drop flags, bit b for buffer b |

## Verification
Directed slots come first, so that each rule shows up on its own:
- A lone cell into empty buffers exposes the same-slot pass-through.
- A full four-lane burst shows the lane-to-buffer rotation, with its first cell passed through and the rest drained one per slot in order.
- Empty slots and strobe-less cycles separate waiting from holding.

A long run of four-lane bursts then fills every buffer, which shows whether drops are judged on fullness at the start of the slot and whether the write pointer still steps past a dropped cell. Random lane counts mixed with random strobe gaps then move both pointers to every offset against each other. Each such run is compared with a queue model kept in the bench.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  // Buffer and lane count; must be a power of two so pointers wrap naturally.
  localparam int unsigned NUM_BUF = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_BUF);

  typedef logic [IDX_W-1:0] bufIdx_t;

  // Strobes from control to datapath for one slot.
  typedef struct packed {
    logic                        slot;
    logic [NUM_BUF-1:0]          push;
    logic [NUM_BUF-1:0]          drop;
    bufIdx_t [NUM_BUF-1:0]       srcLane;
    logic                        pop;
    logic                        bypass;
    bufIdx_t                     bypassLane;
    bufIdx_t                     rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/rrs_fifo.sv
module rrs_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrIdx, rdIdx;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrIdx] <= din;
        wrIdx <= (wrIdx == PTR_W'(DEPTH - 1)) ? '0 : wrIdx + PTR_W'(1);
      end
      if (pop) begin
        rdIdx <= (rdIdx == PTR_W'(DEPTH - 1)) ? '0 : rdIdx + PTR_W'(1);
      end
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (pop && !push) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotStb,
  input  logic [NUM_BUF-1:0] laneValid,
  input  logic [NUM_BUF-1:0] bufEmpty,
  input  logic [NUM_BUF-1:0] bufFull,
  output ctrlStrobe_t        strb
);
  bufIdx_t wrPtr, rdPtr;
  logic [NUM_BUF-1:0] hit;
  logic rdEmpty;

  always_comb begin
    strb       = '0;
    strb.slot  = slotStb;
    strb.rdSel = rdPtr;
    rdEmpty    = bufEmpty[rdPtr];
    hit        = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      bufIdx_t laneIdx;
      laneIdx        = bufIdx_t'(b) - wrPtr;
      strb.srcLane[b] = laneIdx;
      hit[b]         = laneValid[laneIdx];
    end
    strb.bypass     = slotStb && rdEmpty && hit[rdPtr];
    strb.bypassLane = rdPtr - wrPtr;
    strb.pop        = slotStb && !rdEmpty;
    for (int b = 0; b < NUM_BUF; b++) begin
      strb.push[b] = slotStb && hit[b] && !bufFull[b] &&
                     !(strb.bypass && (bufIdx_t'(b) == rdPtr));
      strb.drop[b] = slotStb && hit[b] && bufFull[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= bufIdx_t'(1);
      rdPtr <= bufIdx_t'(1);
    end else if (slotStb) begin
      wrPtr <= wrPtr + bufIdx_t'($countones(laneValid));
      if (strb.pop || strb.bypass) rdPtr <= rdPtr + bufIdx_t'(1);
    end
  end
endmodule

// File: rtl/rrs_dp.sv
module rrs_dp
  import rrs_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strb,
  input  logic [NUM_BUF-1:0][WIDTH-1:0]   laneData,
  output logic [NUM_BUF-1:0]              bufEmpty,
  output logic [NUM_BUF-1:0]              bufFull,
  output logic                            cellValid,
  output logic [WIDTH-1:0]                cellData,
  output logic [NUM_BUF-1:0]              overflow
);
  logic [NUM_BUF-1:0][WIDTH-1:0] headData;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    rrs_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (strb.push[b]),
      .pop   (strb.pop && (strb.rdSel == bufIdx_t'(b))),
      .din   (laneData[strb.srcLane[b]]),
      .head  (headData[b]),
      .empty (bufEmpty[b]),
      .full  (bufFull[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellValid <= 1'b0;
      cellData  <= '0;
      overflow  <= '0;
    end else if (strb.slot) begin
      overflow  <= overflow | strb.drop;
      cellValid <= strb.pop || strb.bypass;
      if (strb.bypass)   cellData <= laneData[strb.bypassLane];
      else if (strb.pop) cellData <= headData[strb.rdSel];
    end
  end
endmodule

// File: rtl/rr_spread_buf.sv
module rr_spread_buf
  import rrs_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     slotStb,
  input  logic [NUM_BUF-1:0]       laneValid,
  input  logic [NUM_BUF*WIDTH-1:0] laneData,
  output logic                     cellValid,
  output logic [WIDTH-1:0]         cellData,
  output logic [NUM_BUF-1:0]       overflow
);
  ctrlStrobe_t strb;
  logic [NUM_BUF-1:0] bufEmpty, bufFull;
  logic [NUM_BUF-1:0][WIDTH-1:0] laneArr;

  assign laneArr = laneData;

  rrs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .laneValid(laneValid),
    .bufEmpty(bufEmpty), .bufFull(bufFull), .strb(strb)
  );

  rrs_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneData(laneArr),
    .bufEmpty(bufEmpty), .bufFull(bufFull),
    .cellValid(cellValid), .cellData(cellData), .overflow(overflow)
  );
endmodule

// File: rtl/rr_spread_buf_chk.sv
module rr_spread_buf_chk
  import rrs_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               slotStb,
  input logic [NUM_BUF-1:0] laneValid,
  input logic               cellValid,
  input logic [WIDTH-1:0]   cellData,
  input logic [NUM_BUF-1:0] overflow
);
  // R6
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((overflow & $past(overflow)) == $past(overflow)));

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow != $past(overflow)) |-> $past(slotStb && (|laneValid)));

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotStb |=> ($stable(cellValid) && $stable(cellData)));

  // R7
  rise_on_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cellValid) |-> $past(slotStb));

  // R9
  packed_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotStb |-> ((laneValid & (laneValid + NUM_BUF'(1))) == '0));
endmodule

bind rr_spread_buf rr_spread_buf_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .slotStb(slotStb), .laneValid(laneValid),
  .cellValid(cellValid), .cellData(cellData), .overflow(overflow)
);

// File: tb/rr_spread_buf_tb.sv
module rr_spread_buf_tb;
  localparam int W = 8;
  localparam int D = 4;
  localparam int L = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rstN, slotStb;
  logic [L-1:0]   laneValid;
  logic [L*W-1:0] laneData;
  logic           cellValid;
  logic [W-1:0]   cellData;
  logic [L-1:0]   overflow;

  rr_spread_buf #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .laneValid(laneValid),
    .laneData(laneData), .cellValid(cellValid), .cellData(cellData),
    .overflow(overflow)
  );

  int total = 0;
  int bad = 0;
  bit [W-1:0] mq[L][$];
  int wp, rp;
  logic [L-1:0] expOvf;
  logic expV;
  logic [W-1:0] expD;
  logic [W-1:0] seqNo;
  logic [W-1:0] lastOut;
  bit orderChk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; slotStb = 1'b0; laneValid = '0; laneData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int b = 0; b < L; b++) mq[b].delete();
    wp = 1; rp = 1; expOvf = '0; expV = 1'b0; expD = '0;
    check(cellValid === 1'b0, "R1 cellValid after reset", cellValid, 0);
    check(overflow === '0, "R1 overflow after reset", overflow, 0);
  endtask

  // One clock: drive k packed lanes, strobe or not, then compare with model.
  task automatic slot(input int k, input bit stb, input string tag);
    logic [W-1:0] d[L];
    bit rEmpty, bypassed;
    bit fullB[L];
    for (int i = 0; i < L; i++) begin
      d[i] = (i < k) ? seqNo + W'(i) : W'($urandom);
      laneData[i*W +: W] = d[i];
    end
    laneValid = L'((1 << k) - 1);
    slotStb = stb;
    if (stb) begin
      seqNo = seqNo + W'(k);
      rEmpty = (mq[rp].size() == 0);
      for (int b = 0; b < L; b++) fullB[b] = (mq[b].size() == D);
      expV = 1'b0;
      bypassed = 1'b0;
      if (!rEmpty) begin
        expD = mq[rp].pop_front();
        expV = 1'b1;
      end
      for (int i = 0; i < k; i++) begin
        int b;
        b = (wp + i) % L;
        if (b == rp && rEmpty && !bypassed) begin
          expV = 1'b1; expD = d[i]; bypassed = 1'b1;
        end else if (fullB[b]) begin
          expOvf[b] = 1'b1;
        end else begin
          mq[b].push_back(d[i]);
        end
      end
      wp = (wp + k) % L;
      if (expV) rp = (rp + 1) % L;
    end
    @(posedge clk);
    @(negedge clk);
    check(cellValid === expV, {tag, " cellValid"}, cellValid, expV);
    if (expV) check(cellData === expD, {tag, " cellData"}, cellData, expD);
    check(overflow === expOvf, "R6 overflow flags", overflow, expOvf);
    if (orderChk && stb && cellValid) begin
      check(cellData === lastOut + W'(1), "R8 arrival order", cellData, lastOut + W'(1));
      lastOut = cellData;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    seqNo = '0;
    orderChk = 1'b0;
    doReset();
    // R5: lone cell into empty buffers passes straight through
    slot(1, 1'b1, "R5 bypass single");
    lastOut = expD;
    orderChk = 1'b1;
    // R4: empty slot, no output, pointer waits
    slot(0, 1'b1, "R4 empty wait");
    // R2: four lanes spread across buffers 2,3,0,1
    slot(4, 1'b1, "R2 burst spread");
    // R7: no strobe, lanes ignored, output held
    slot(3, 1'b0, "R7 no strobe hold");
    repeat (3) slot(0, 1'b1, "R3 drain");
    slot(0, 1'b1, "R4 empty after drain");
    slot(2, 1'b1, "R5 resume at waiting buffer");
    slot(3, 1'b1, "R2 partial burst");
    repeat (5) slot(1, 1'b1, "R3 steady");
    repeat (6) slot(0, 1'b1, "R7 idle");
    orderChk = 1'b0;

    // R6: sustained four-lane load overfills buffers
    doReset();
    repeat (12) slot(4, 1'b1, "R6 overload");
    repeat (20) slot(0, 1'b1, "R3 drain after overload");

    // Random lane counts and strobe gaps
    doReset();
    for (int n = 0; n < 600; n++)
      slot($urandom_range(0, 4), ($urandom_range(0, 5) != 0), "R3 random");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule